// File: doc/BRIEF.md
# Byte-Wide Register-Window FIFO with Transfer Countdown

This block is a sixteen-entry, byte-wide queue that a processor reaches only through three 8-bit registers, with a second, device-side port that pushes and pops bytes through a small ready/valid handshake. Through the window the processor reads the queue's occupancy flags and requests a flush. It moves bytes in and out of the queue through a data register. It also loads a byte count for a programmed (non-DMA) transfer and reads back how many bytes are still outstanding.

The flush is handled by a two-state machine. `FL_IDLE` is the normal state. A control write with the flush bit set moves it to `FL_FLUSH` (transition *flush request*). It stays in `FL_FLUSH` for exactly one cycle: during that cycle both ports are blocked, and at the end of it the pointers and occupancy clear. It then returns to `FL_IDLE` unconditionally (transition *flush complete*), so the flush bit drops back to zero by itself. The register decoder maps each access to one of four selections: `SEL_CTRL`, `SEL_DATA`, `SEL_SIZE`, and `SEL_NONE` for an unmapped offset.

Every byte that the processor actually moves through the data register decrements the countdown. When the countdown goes from one to zero, a single-cycle completion pulse is raised.

Top module: `cpu_fifo_port`

## Requirements
- R1: After reset the queue is empty, the countdown is 0, `reg_rdata` is 0x00, `xfer_done` is low, `dev_push_ready` is high and `dev_pop_valid` is low.
- R2: A read at offset 0x31 returns the status byte: bit 0 = empty (occupancy 0), bit 1 = full (occupancy 16), bit 2 = flush in progress, bits 7:3 = 0.
- R3: Writing 0x31 with bit 2 set starts a flush lasting the following cycle. A status read in that cycle shows bit 2 = 1, and a read after it shows bit 2 = 0 with the queue empty. Data-port accesses and device pushes or pops in that cycle are dropped, and a data-port read in that cycle returns 0x00.
- R4: The queue holds 16 bytes. A data-port write (offset 0x32) while full is dropped, and the stored contents and their order are unchanged.
- R5: A data-port read while empty returns 0x00 and changes neither the occupancy nor the read position.
- R6: Bytes leave the queue in the order they entered, whichever port pushed or pops them.
- R7: A write at offset 0x33 loads the 8-bit countdown. A read at 0x33 returns the current remaining count.
- R8: Each byte accepted by a data-port write or returned by a data-port read decrements the countdown by one. Dropped writes and empty reads leave it unchanged, and it holds at 0.
- R9: `xfer_done` is high for exactly one cycle, in the first cycle the countdown reads 0 after a decrement from 1.
- R10: A push and a pop in the same cycle, with the queue neither empty nor full, leave the occupancy unchanged.
- R11: `reg_rdata` updates on the clock edge that samples `reg_rd` and otherwise holds. Reads of unmapped offsets return 0x00.
- R12: `dev_push_ready` is low when the queue is full, while flushing, or when the processor writes the data port in the same cycle. `dev_pop_valid` is low when the queue is empty, while flushing, or when the processor reads the data port in the same cycle. `dev_pop_data` shows the oldest byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_addr | input | 8 | Register offset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Registered read data, valid the cycle after `reg_rd` |
| dev_push | input | 1 | Device push request |
| dev_push_data | input | 8 | Byte to push from the device side |
| dev_push_ready | output | 1 | Device push is accepted this cycle |
| dev_pop | input | 1 | Device pop request |
| dev_pop_valid | output | 1 | A byte is available to the device this cycle |
| dev_pop_data | output | 8 | Oldest byte in the queue |
| xfer_done | output | 1 | One-cycle pulse when the countdown reaches zero |

## Verification
The assertions assume that `reg_wr` and `reg_rd` are never raised in the same cycle, that inputs never carry X after reset, and that the device side only counts a transfer when its request meets ready or valid. The bench drives one operation per cycle from tasks, never raising both register strobes together, and it judges every device request against the handshake outputs sampled before the edge. Constrained random operations are mixed with directed fills past capacity, flushes that collide with other accesses, simultaneous push and pop, and countdowns that cross zero.

// File: rtl/fifo_port_pkg.sv
package fifo_port_pkg;

    typedef enum logic [0:0] {
        FL_IDLE  = 1'b0,
        FL_FLUSH = 1'b1
    } flush_state_e;

    typedef enum logic [1:0] {
        SEL_NONE = 2'd0,
        SEL_CTRL = 2'd1,
        SEL_DATA = 2'd2,
        SEL_SIZE = 2'd3
    } reg_sel_e;

endpackage

// File: rtl/flush_ctrl.sv
module flush_ctrl
    import fifo_port_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic flush_req,
    output logic flush_active
);

    flush_state_e state_q;
    flush_state_e state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FL_IDLE:  if (flush_req) state_d = FL_FLUSH;
            FL_FLUSH: state_d = FL_IDLE;
            default:  state_d = FL_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= FL_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        unique case (state_q)
            FL_IDLE:  flush_active = 1'b0;
            FL_FLUSH: flush_active = 1'b1;
            default:  flush_active = 1'b0;
        endcase
    end

    // R3: the flush bit clears itself after a single cycle
    assert_flush_self_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == FL_FLUSH) |=> (state_q == FL_IDLE));

    // R3: a flush only starts on request
    assert_flush_needs_req_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == FL_IDLE && !flush_req) |=> (state_q == FL_IDLE));

endmodule

// File: rtl/fifo_store.sv
module fifo_store #(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 16
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      clr,
    input  logic                      push,
    input  logic [DATA_W-1:0]         push_data,
    input  logic                      pop,
    output logic [DATA_W-1:0]         head_data,
    output logic                      full,
    output logic                      empty,
    output logic [$clog2(DEPTH+1)-1:0] occ
);

    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);
    localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

    logic [DATA_W-1:0] mem [DEPTH];
    logic [AW-1:0]     wptr_q;
    logic [AW-1:0]     rptr_q;
    logic [CW-1:0]     occ_q;
    logic              do_push;
    logic              do_pop;

    assign full      = (occ_q == FULL_CNT);
    assign empty     = (occ_q == '0);
    assign occ       = occ_q;
    assign head_data = mem[rptr_q];
    assign do_push   = push && !full && !clr;
    assign do_pop    = pop && !empty && !clr;

    always_ff @(posedge clk) begin
        if (do_push) mem[wptr_q] <= push_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wptr_q <= '0;
            rptr_q <= '0;
            occ_q  <= '0;
        end else if (clr) begin
            wptr_q <= '0;
            rptr_q <= '0;
            occ_q  <= '0;
        end else begin
            if (do_push) wptr_q <= (wptr_q == LAST) ? '0 : wptr_q + 1'b1;
            if (do_pop)  rptr_q <= (rptr_q == LAST) ? '0 : rptr_q + 1'b1;
            unique case ({do_push, do_pop})
                2'b10:   occ_q <= occ_q + 1'b1;
                2'b01:   occ_q <= occ_q - 1'b1;
                default: occ_q <= occ_q;
            endcase
        end
    end

    assert_no_overflow_R4: assert property (@(posedge clk) disable iff (!rst_n)
        occ_q <= FULL_CNT);

    assert_drop_when_full_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (full && !pop && !clr) |=> (full && $stable(wptr_q)));

    assert_no_underflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (empty && !push && !clr) |=> (empty && $stable(rptr_q)));

    assert_push_pop_balance_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (push && pop && !full && !empty && !clr) |=> $stable(occ_q));

endmodule

// File: rtl/xfer_counter.sv
module xfer_counter #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             dec,
    output logic [CNT_W-1:0] count,
    output logic             done
);

    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic [CNT_W-1:0] count_q;
    logic             done_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count_q <= '0;
            done_q  <= 1'b0;
        end else begin
            done_q <= dec && !load && (count_q == ONE);
            if (load)                       count_q <= load_val;
            else if (dec && count_q != '0)  count_q <= count_q - 1'b1;
        end
    end

    assign count = count_q;
    assign done  = done_q;

    assert_hold_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (count_q == '0 && !load) |=> (count_q == '0));

    assert_step_one_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && count_q != '0) |=> (count_q == $past(count_q) || count_q == $past(count_q) - 1'b1));

    assert_done_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |=> !done_q);

    assert_done_at_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |-> (count_q == '0));

endmodule

// File: rtl/cpu_fifo_port.sv
module cpu_fifo_port
    import fifo_port_pkg::*;
#(
    parameter int          DATA_W    = 8,
    parameter int          DEPTH     = 16,
    parameter int          RA_W      = 8,
    parameter logic [7:0]  CTRL_OFS  = 8'h31,
    parameter logic [7:0]  DATA_OFS  = 8'h32,
    parameter logic [7:0]  SIZE_OFS  = 8'h33,
    parameter int          FLUSH_BIT = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [RA_W-1:0]   reg_addr,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              dev_push,
    input  logic [DATA_W-1:0] dev_push_data,
    output logic              dev_push_ready,
    input  logic              dev_pop,
    output logic              dev_pop_valid,
    output logic [DATA_W-1:0] dev_pop_data,
    output logic              xfer_done
);

    localparam int CW     = $clog2(DEPTH + 1);
    localparam int STAT_W = 3;

    reg_sel_e          sel;
    logic              flush_active;
    logic              flush_req;
    logic              fifo_full;
    logic              fifo_empty;
    logic [CW-1:0]     fifo_occ;
    logic [DATA_W-1:0] head_data;
    logic              cpu_wr_data;
    logic              cpu_rd_data;
    logic              cpu_push_ok;
    logic              cpu_pop_ok;
    logic              dev_push_ok;
    logic              dev_pop_ok;
    logic              fifo_push;
    logic              fifo_pop;
    logic [DATA_W-1:0] fifo_push_data;
    logic [DATA_W-1:0] xfer_count;
    logic [DATA_W-1:0] status_byte;
    logic [DATA_W-1:0] rd_mux;
    logic [DATA_W-1:0] rdata_q;

    // Offset decode
    always_comb begin
        if (reg_addr == RA_W'(CTRL_OFS))      sel = SEL_CTRL;
        else if (reg_addr == RA_W'(DATA_OFS)) sel = SEL_DATA;
        else if (reg_addr == RA_W'(SIZE_OFS)) sel = SEL_SIZE;
        else                                  sel = SEL_NONE;
    end

    assign flush_req = reg_wr && (sel == SEL_CTRL) && reg_wdata[FLUSH_BIT] && !flush_active;

    flush_ctrl u_flush (
        .clk          (clk),
        .rst_n        (rst_n),
        .flush_req    (flush_req),
        .flush_active (flush_active)
    );

    // Access arbitration: processor first, device side gets the rest
    assign cpu_wr_data    = reg_wr && (sel == SEL_DATA) && !flush_active;
    assign cpu_rd_data    = reg_rd && (sel == SEL_DATA) && !flush_active;
    assign cpu_push_ok    = cpu_wr_data && !fifo_full;
    assign cpu_pop_ok     = cpu_rd_data && !fifo_empty;
    assign dev_push_ready = !flush_active && !fifo_full && !cpu_wr_data;
    assign dev_pop_valid  = !flush_active && !fifo_empty && !cpu_rd_data;
    assign dev_push_ok    = dev_push && dev_push_ready;
    assign dev_pop_ok     = dev_pop && dev_pop_valid;
    assign fifo_push      = cpu_push_ok || dev_push_ok;
    assign fifo_pop       = cpu_pop_ok || dev_pop_ok;
    assign fifo_push_data = cpu_wr_data ? reg_wdata : dev_push_data;
    assign dev_pop_data   = head_data;

    fifo_store #(
        .DATA_W (DATA_W),
        .DEPTH  (DEPTH)
    ) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (flush_active),
        .push      (fifo_push),
        .push_data (fifo_push_data),
        .pop       (fifo_pop),
        .head_data (head_data),
        .full      (fifo_full),
        .empty     (fifo_empty),
        .occ       (fifo_occ)
    );

    xfer_counter #(
        .CNT_W (DATA_W)
    ) u_count (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (reg_wr && (sel == SEL_SIZE)),
        .load_val (reg_wdata),
        .dec      (cpu_push_ok || cpu_pop_ok),
        .count    (xfer_count),
        .done     (xfer_done)
    );

    assign status_byte = {{(DATA_W-STAT_W){1'b0}}, flush_active, fifo_full, fifo_empty};

    always_comb begin
        unique case (sel)
            SEL_CTRL: rd_mux = status_byte;
            SEL_DATA: rd_mux = cpu_pop_ok ? head_data : '0;
            SEL_SIZE: rd_mux = xfer_count;
            default:  rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      rdata_q <= '0;
        else if (reg_rd) rdata_q <= rd_mux;
    end

    assign reg_rdata = rdata_q;

    assert_flush_empties_R3: assert property (@(posedge clk) disable iff (!rst_n)
        flush_active |=> (fifo_empty && fifo_occ == '0));

    assert_rdata_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_rd |=> $stable(reg_rdata));

    assert_push_ready_full_R12: assert property (@(posedge clk) disable iff (!rst_n)
        dev_push_ready |-> !fifo_full);

    assert_pop_valid_empty_R12: assert property (@(posedge clk) disable iff (!rst_n)
        dev_pop_valid |-> !fifo_empty);

    assert_empty_read_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && sel == SEL_DATA && fifo_empty) |=> (reg_rdata == '0));

endmodule

// File: tb/tb_cpu_fifo_port.sv
`timescale 1ns/1ps
module tb_cpu_fifo_port;

    localparam logic [7:0] A_CTRL = 8'h31;
    localparam logic [7:0] A_DATA = 8'h32;
    localparam logic [7:0] A_SIZE = 8'h33;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] reg_addr = '0;
    logic       reg_wr = 1'b0;
    logic       reg_rd = 1'b0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       dev_push = 1'b0;
    logic [7:0] dev_push_data = '0;
    logic       dev_push_ready;
    logic       dev_pop = 1'b0;
    logic       dev_pop_valid;
    logic [7:0] dev_pop_data;
    logic       xfer_done;

    always #2.5 clk = ~clk;

    cpu_fifo_port dut (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .dev_push(dev_push),
        .dev_push_data(dev_push_data), .dev_push_ready(dev_push_ready), .dev_pop(dev_pop),
        .dev_pop_valid(dev_pop_valid), .dev_pop_data(dev_pop_data), .xfer_done(xfer_done)
    );

    int checks = 0;
    int errors = 0;
    logic [7:0] q[$];
    int cnt_m = 0;
    logic       s_ready, s_valid, s_done;
    logic [7:0] s_pdata, s_rdata;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_status();
        return {5'b0, 1'b0, q.size() == 16, q.size() == 0};
    endfunction

    // One operation per cycle; called at a falling edge, returns at the next one
    task automatic cyc(input logic wr, input logic rd, input logic [7:0] addr,
                       input logic [7:0] wd, input logic dpush, input logic [7:0] dpd,
                       input logic dpop);
        reg_wr = wr; reg_rd = rd; reg_addr = addr; reg_wdata = wd;
        dev_push = dpush; dev_push_data = dpd; dev_pop = dpop;
        #1;
        s_ready = dev_push_ready; s_valid = dev_pop_valid; s_pdata = dev_pop_data;
        @(posedge clk);
        #0.5;
        reg_wr = 1'b0; reg_rd = 1'b0; dev_push = 1'b0; dev_pop = 1'b0;
        @(negedge clk);
        s_rdata = reg_rdata; s_done = xfer_done;
    endtask

    function automatic logic step_count();
        if (cnt_m > 0) begin
            cnt_m--;
            return cnt_m == 0;
        end
        return 1'b0;
    endfunction

    task automatic m_cpu_write(input logic [7:0] d, input string tag);
        logic ed = 1'b0;
        cyc(1, 0, A_DATA, d, 0, 0, 0);
        if (q.size() < 16) begin
            q.push_back(d);
            ed = step_count();
        end
        chk({tag, " done after data write (R9)"}, s_done, ed);
    endtask

    task automatic m_cpu_read(input string tag);
        logic [7:0] e = 8'h00;
        logic ed = 1'b0;
        cyc(0, 1, A_DATA, 0, 0, 0, 0);
        if (q.size() > 0) begin
            e = q.pop_front();
            ed = step_count();
        end
        chk({tag, " data read (R6/R5)"}, s_rdata, e);
        chk({tag, " done after data read (R9)"}, s_done, ed);
    endtask

    task automatic m_dev_push(input logic [7:0] d, input string tag);
        logic er;
        er = q.size() < 16;
        cyc(0, 0, 0, 0, 1, d, 0);
        chk({tag, " push ready (R12)"}, s_ready, er);
        if (er) q.push_back(d);
    endtask

    task automatic m_dev_pop(input string tag);
        logic ev;
        ev = q.size() > 0;
        cyc(0, 0, 0, 0, 0, 0, 1);
        chk({tag, " pop valid (R12)"}, s_valid, ev);
        if (ev) chk({tag, " pop data order (R6)"}, s_pdata, q.pop_front());
    endtask

    task automatic m_rd(input logic [7:0] addr, input logic [7:0] e, input string tag);
        cyc(0, 1, addr, 0, 0, 0, 0);
        chk(tag, s_rdata, e);
    endtask

    task automatic m_load(input logic [7:0] v);
        cyc(1, 0, A_SIZE, v, 0, 0, 0);
        cnt_m = v;
    endtask

    task automatic m_flush(input string tag);
        logic [7:0] e;
        cyc(1, 0, A_CTRL, 8'h04, 0, 0, 0);
        e = exp_status() | 8'h04;
        cyc(0, 1, A_CTRL, 0, 1, 8'hA5, 1);
        chk({tag, " status during flush (R3)"}, s_rdata, e);
        chk({tag, " push blocked in flush (R12)"}, s_ready, 1'b0);
        chk({tag, " pop blocked in flush (R12)"}, s_valid, 1'b0);
        q.delete();
        m_rd(A_CTRL, 8'h01, {tag, " flush bit self-clears, empty (R3)"});
    endtask

    task automatic run_main();
        // Reset state
        repeat (3) @(negedge clk);
        chk("R1 rdata at reset", reg_rdata, 8'h00);
        chk("R1 done at reset", xfer_done, 1'b0);
        chk("R1 push ready at reset", dev_push_ready, 1'b1);
        chk("R1 pop valid at reset", dev_pop_valid, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);
        m_rd(A_CTRL, 8'h01, "R1 R2 status after reset");
        m_rd(A_SIZE, 8'h00, "R1 countdown after reset");
        m_rd(8'h30, 8'h00, "R11 unmapped offset reads zero");

        // Fill to capacity, overflow dropped
        m_load(8'd20);
        for (int i = 0; i < 16; i++) m_cpu_write(8'(i * 7 + 3), "R4 fill");
        m_rd(A_CTRL, 8'h02, "R2 R4 status full");
        m_rd(A_SIZE, 8'd4, "R7 R8 countdown after 16 writes");
        m_cpu_write(8'hEE, "R4 write when full");
        m_rd(A_SIZE, 8'd4, "R8 dropped write keeps countdown");
        m_dev_push(8'h77, "R12 device push when full");
        for (int i = 0; i < 16; i++) m_cpu_read("R4 R6 drain");
        m_rd(A_SIZE, 8'd0, "R8 countdown held at zero");
        m_cpu_read("R5 empty read");
        m_rd(A_CTRL, 8'h01, "R5 still empty");

        // Same-cycle push and pop
        m_dev_push(8'h11, "R6 dev push a");
        m_dev_push(8'h22, "R6 dev push b");
        m_dev_push(8'h33, "R6 dev push c");
        cyc(1, 0, A_DATA, 8'h44, 0, 0, 1);
        chk("R10 pop valid with cpu write", s_valid, 1'b1);
        chk("R10 pop data with cpu write", s_pdata, q.pop_front());
        q.push_back(8'h44);
        m_rd(A_CTRL, 8'h00, "R10 occupancy unchanged, not empty");
        // Processor wins over the device in the same cycle
        cyc(1, 0, A_DATA, 8'h55, 1, 8'h66, 0);
        chk("R12 push ready low on cpu write", s_ready, 1'b0);
        q.push_back(8'h55);
        cyc(0, 1, A_DATA, 0, 0, 0, 1);
        chk("R12 pop valid low on cpu read", s_valid, 1'b0);
        chk("R6 cpu read oldest", s_rdata, q.pop_front());
        m_dev_pop("R6 device pop");
        m_cpu_read("R6 cpu read");

        // Flush with contents, then flush colliding with a data write
        m_flush("R3 flush a");
        m_cpu_write(8'h90, "R3 refill");
        cyc(1, 0, A_CTRL, 8'h04, 0, 0, 0);
        cyc(1, 0, A_DATA, 8'h91, 0, 0, 0);
        q.delete();
        m_rd(A_CTRL, 8'h01, "R3 write in flush cycle dropped");
        m_cpu_write(8'h92, "R3 after flush");
        cyc(1, 0, A_CTRL, 8'h04, 0, 0, 0);
        cyc(0, 1, A_DATA, 0, 0, 0, 0);
        chk("R3 data read in flush cycle returns zero", s_rdata, 8'h00);
        q.delete();
        m_rd(A_CTRL, 8'h01, "R3 empty after flush");

        // Countdown crossing zero and empty reads not counting
        m_load(8'd2);
        m_cpu_write(8'hA1, "R8 dec 1");
        m_cpu_write(8'hA2, "R9 dec to zero");
        cyc(0, 0, 0, 0, 0, 0, 0);
        chk("R9 done lasts one cycle", s_done, 1'b0);
        m_load(8'd1);
        m_cpu_read("R8 read a");
        m_cpu_read("R8 read b");
        m_cpu_read("R8 R5 empty read after done");
        m_rd(A_SIZE, 8'd0, "R8 countdown at zero");

        // Constrained random mix
        void'($urandom(32'd20240611));
        for (int n = 0; n < 800; n++) begin
            int r;
            r = int'($urandom % 16);
            if (r < 4)       m_cpu_write(8'($urandom), "R4 R6 random write");
            else if (r < 8)  m_cpu_read("R5 R6 random read");
            else if (r < 10) m_dev_push(8'($urandom), "R12 random push");
            else if (r < 12) m_dev_pop("R12 random pop");
            else if (r == 12) m_rd(A_CTRL, exp_status(), "R2 random status");
            else if (r == 13) m_rd(A_SIZE, 8'(cnt_m), "R7 random countdown");
            else if (r == 14) m_load(8'($urandom % 12));
            else if ($urandom % 4 == 0) m_flush("R3 random flush");
            else m_rd(A_CTRL, exp_status(), "R2 random status");
        end
    endtask

    initial begin
        fork
            run_main();
            begin
                repeat (150000) @(posedge clk);
                errors++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        disable fork;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule